// File: doc/BRIEF.md
# Dual-Mode Programmable Frequency Divider

This block divides a local-oscillator signal by a programmable modulus and delivers one short pulse per division period to a downstream phase comparator. Both oscillator signals arrive as single-cycle strobes in one fabric clock domain. `hb_tick` is the high-band source. `lb_tick` is the low-band source. Each strobe marks one oscillator edge.

Two mode bits pick the source and the way the 16-bit divisor word is read:

- **High band:** the high-band source passes through a fixed divide-by-two stage before the counter. The overall ratio is therefore twice the programmed word.
- **Low band, wide:** the low-band source is counted directly, and all 16 bits of the word are used.
- **Low band, short:** only the upper twelve bits of the word form the modulus.

A setting below the legal minimum of the active mode is raised to that minimum. A new word or mode written while the divider runs is taken only when the current period ends.

An inhibit input stops the divider and clears its progress. When inhibit is released, a fresh full period starts.

Top module: `fdiv_top`

## Requirements
- R1: With `hb_sel`=1 a pulse is produced once per 2*N `hb_tick` strobes, where N is `div_word` read as a 16-bit unsigned value (bit 0 is the LSB); 0x07DE gives a pulse every 4028 strobes.
- R2: With `hb_sel`=0 and `lb_wide`=1 a pulse is produced once per N `lb_tick` strobes, N being all 16 bits of `div_word` with bit 0 as LSB.
- R3: With `hb_sel`=0 and `lb_wide`=0, N is `div_word[15:4]` with bit 4 as LSB, and `div_word[3:0]` has no effect on the period.
- R4: A value of N below 272 in either 16-bit mode is treated as 272, and a value below 4 in the 12-bit mode is treated as 4; values equal to the minimum give exactly that period.
- R5: While `inhibit` is 1 no pulse is produced and no progress is kept. After release, the first pulse comes after one full period counted from the release: N strobes in low band, 2*N in high band.
- R6: A change of `div_word`, `hb_sel` or `lb_wide` during a period leaves that period's length unchanged; the new setting governs every period that follows.
- R7: `div_pulse` is high for exactly one clock cycle. It rises in the cycle after the clock edge that sampled the strobe completing the period.
- R8: Strobes on the source that the active mode does not select have no effect on pulse timing.
- R9: During and after synchronous reset `div_pulse` is 0. Counting then starts from zero with the setting present at the port during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_tick | input | 1 | One-cycle strobe per high-band oscillator edge |
| lb_tick | input | 1 | One-cycle strobe per low-band oscillator edge |
| div_word | input | 16 | Programmed divisor word |
| hb_sel | input | 1 | 1 selects the high band with divide-by-two |
| lb_wide | input | 1 | In low band: 1 = 16-bit modulus, 0 = 12-bit modulus from bits 15..4 |
| inhibit | input | 1 | 1 stops the divider and clears its progress |
| div_pulse | output | 1 | Registered one-cycle pulse per division period |

## Verification
The bench builds the block with its default parameters:

- a 16-bit word;
- a 12-bit short modulus;
- minimums of 272 and 4;
- a prescale factor of 2.

With these values, the worked high-band example and both clamp floors can be reached in a few thousand strobes. At the 12-bit floor of 4, several back-to-back short periods, and a mid-period switch from wide to short mode, can be observed within a few hundred strobes. The odd-strobe inhibit case checks that the divide-by-two phase is cleared along with the main count.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  typedef enum logic [1:0] {
    MODE_LB_SHORT = 2'b00,
    MODE_LB_WIDE  = 2'b01,
    MODE_HB       = 2'b10
  } fdiv_mode_e;
endpackage

// File: rtl/fdiv_ratio.sv
module fdiv_ratio
  import fdiv_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int SHORT_W   = 12,
  parameter int WIDE_MIN  = 272,
  parameter int SHORT_MIN = 4
) (
  input  logic [DIV_W-1:0] div_word,
  input  logic             hb_sel,
  input  logic             lb_wide,
  output fdiv_mode_e       mode,
  output logic [DIV_W-1:0] ratio
);
  localparam int SHORT_LSB = DIV_W - SHORT_W;
  localparam logic [DIV_W-1:0] WIDE_FLOOR  = DIV_W'(WIDE_MIN);
  localparam logic [DIV_W-1:0] SHORT_FLOOR = DIV_W'(SHORT_MIN);

  logic [DIV_W-1:0] short_val;

  always_comb begin
    short_val = {{SHORT_LSB{1'b0}}, div_word[DIV_W-1:SHORT_LSB]};
    if (hb_sel)       mode = MODE_HB;
    else if (lb_wide) mode = MODE_LB_WIDE;
    else              mode = MODE_LB_SHORT;
    if (mode == MODE_LB_SHORT)
      ratio = (short_val < SHORT_FLOOR) ? SHORT_FLOOR : short_val;
    else
      ratio = (div_word < WIDE_FLOOR) ? WIDE_FLOOR : div_word;
  end
endmodule

// File: rtl/fdiv_prescale.sv
module fdiv_prescale #(
  parameter int PRE_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick_in,
  output logic tick_out
);
  generate
    if (PRE_DIV > 1) begin : g_div
      localparam int PW = $clog2(PRE_DIV);
      localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);
      logic [PW-1:0] phase;
      always_ff @(posedge clk) begin
        if (rst || clr)   phase <= '0;
        else if (tick_in) phase <= (phase == LAST) ? '0 : phase + 1'b1;
      end
      assign tick_out = tick_in && (phase == LAST);
    end else begin : g_pass
      assign tick_out = tick_in;
    end
  endgenerate
endmodule

// File: rtl/fdiv_counter.sv
module fdiv_counter
  import fdiv_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             event_i,
  input  logic [DIV_W-1:0] next_n,
  input  fdiv_mode_e       next_mode,
  output logic [DIV_W-1:0] act_n,
  output fdiv_mode_e       act_mode,
  output logic [DIV_W-1:0] cnt,
  output logic             term_pulse
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt        <= '0;
      act_n      <= next_n;
      act_mode   <= next_mode;
      term_pulse <= 1'b0;
    end else begin
      term_pulse <= 1'b0;
      if (event_i) begin
        if (cnt == act_n - 1'b1) begin
          cnt        <= '0;
          act_n      <= next_n;
          act_mode   <= next_mode;
          term_pulse <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fdiv_top.sv
module fdiv_top
  import fdiv_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int SHORT_W   = 12,
  parameter int WIDE_MIN  = 272,
  parameter int SHORT_MIN = 4,
  parameter int PRE_DIV   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hb_tick,
  input  logic             lb_tick,
  input  logic [DIV_W-1:0] div_word,
  input  logic             hb_sel,
  input  logic             lb_wide,
  input  logic             inhibit,
  output logic             div_pulse
);
  fdiv_mode_e       new_mode;
  fdiv_mode_e       act_mode;
  logic [DIV_W-1:0] new_n;
  logic [DIV_W-1:0] act_n;
  logic [DIV_W-1:0] cnt;
  logic             hb_evt;
  logic             cnt_evt;
  logic             pre_clr;

  fdiv_ratio #(
    .DIV_W(DIV_W), .SHORT_W(SHORT_W),
    .WIDE_MIN(WIDE_MIN), .SHORT_MIN(SHORT_MIN)
  ) i_ratio (
    .div_word(div_word), .hb_sel(hb_sel), .lb_wide(lb_wide),
    .mode(new_mode), .ratio(new_n)
  );

  assign pre_clr = inhibit || (act_mode != MODE_HB);

  fdiv_prescale #(.PRE_DIV(PRE_DIV)) i_pre (
    .clk(clk), .rst(rst), .clr(pre_clr),
    .tick_in(hb_tick), .tick_out(hb_evt)
  );

  assign cnt_evt = (act_mode == MODE_HB) ? hb_evt : lb_tick;

  fdiv_counter #(.DIV_W(DIV_W)) i_cnt (
    .clk(clk), .rst(rst), .clr(inhibit), .event_i(cnt_evt),
    .next_n(new_n), .next_mode(new_mode),
    .act_n(act_n), .act_mode(act_mode), .cnt(cnt),
    .term_pulse(div_pulse)
  );
endmodule

// File: rtl/fdiv_checker.sv
module fdiv_checker
  import fdiv_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int WIDE_MIN  = 272,
  parameter int SHORT_MIN = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             hb_tick,
  input logic             lb_tick,
  input logic             inhibit,
  input logic             div_pulse,
  input fdiv_mode_e       act_mode,
  input logic [DIV_W-1:0] act_n,
  input logic [DIV_W-1:0] cnt
);
  localparam logic [DIV_W-1:0] WIDE_FLOOR  = DIV_W'(WIDE_MIN);
  localparam logic [DIV_W-1:0] SHORT_FLOOR = DIV_W'(SHORT_MIN);

  // R5
  inhibit_silent_chk: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> !div_pulse);

  // R7
  single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  // R8
  selected_source_chk: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> $past((act_mode == MODE_HB) ? hb_tick : lb_tick));

  // R4
  ratio_floor_chk: assert property (@(posedge clk) disable iff (rst)
    act_n >= ((act_mode == MODE_LB_SHORT) ? SHORT_FLOOR : WIDE_FLOOR));

  // R6
  count_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < act_n);
endmodule

bind fdiv_top fdiv_checker #(
  .DIV_W(DIV_W), .WIDE_MIN(WIDE_MIN), .SHORT_MIN(SHORT_MIN)
) i_fdiv_checker (
  .clk(clk), .rst(rst), .hb_tick(hb_tick), .lb_tick(lb_tick),
  .inhibit(inhibit), .div_pulse(div_pulse),
  .act_mode(act_mode), .act_n(act_n), .cnt(cnt)
);

// File: tb/test_fdiv_top.sv
`timescale 1ns/1ps
module test_fdiv_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hb_tick = 1'b0;
  logic        lb_tick = 1'b0;
  logic [15:0] div_word = 16'd300;
  logic        hb_sel = 1'b0;
  logic        lb_wide = 1'b1;
  logic        inhibit = 1'b0;
  logic        div_pulse;

  int n_checks = 0;
  int n_fail = 0;
  int pulse_pos [16];
  int npulse;
  int wide_err;

  always #10 clk = ~clk;

  fdiv_top i_fdiv_top (
    .clk(clk), .rst(rst), .hb_tick(hb_tick), .lb_tick(lb_tick),
    .div_word(div_word), .hb_sel(hb_sel), .lb_wide(lb_wide),
    .inhibit(inhibit), .div_pulse(div_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input bit hb, input int n);
    npulse = 0;
    wide_err = 0;
    for (int k = 0; k < 16; k++) pulse_pos[k] = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (div_pulse) wide_err++;
      if (hb) hb_tick = 1'b1; else lb_tick = 1'b1;
      @(negedge clk);
      hb_tick = 1'b0;
      lb_tick = 1'b0;
      if (div_pulse) begin
        if (npulse < 16) pulse_pos[npulse] = i;
        npulse++;
      end
    end
  endtask

  task automatic setup(input bit hb, input bit wide, input logic [15:0] w);
    @(negedge clk);
    hb_sel = hb;
    lb_wide = wide;
    div_word = w;
    inhibit = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 pulse low in reset", int'(div_pulse), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 pulse low after reset", int'(div_pulse), 0);
  endtask

  task automatic t_high_band();
    setup(1'b1, 1'b0, 16'h07DE);
    ticks(1'b1, 8056);
    check("R1 pulse count", npulse, 2);
    check("R1 first period", pulse_pos[0], 4028);
    check("R1 second period", pulse_pos[1], 8056);
    check("R7 pulse width", wide_err, 0);
  endtask

  task automatic t_low_wide();
    setup(1'b0, 1'b1, 16'h1158);
    ticks(1'b0, 4440);
    check("R2 pulse count", npulse, 1);
    check("R2 period", pulse_pos[0], 4440);
    check("R7 pulse width", wide_err, 0);
  endtask

  task automatic t_low_short();
    setup(1'b0, 1'b0, 16'h091F);
    ticks(1'b0, 290);
    check("R3 pulse count", npulse, 2);
    check("R3 periods", pulse_pos[1] - pulse_pos[0], 145);
    check("R3 first period", pulse_pos[0], 145);
    setup(1'b0, 1'b0, 16'h0910);
    ticks(1'b0, 145);
    check("R3 low nibble ignored", pulse_pos[0], 145);
  endtask

  task automatic t_clamp();
    setup(1'b0, 1'b1, 16'd5);
    ticks(1'b0, 544);
    check("R4 wide clamp count", npulse, 2);
    check("R4 wide clamp period", pulse_pos[0], 272);
    setup(1'b0, 1'b1, 16'd272);
    ticks(1'b0, 272);
    check("R4 wide at floor", pulse_pos[0], 272);
    setup(1'b0, 1'b0, 16'h0013);
    ticks(1'b0, 8);
    check("R4 short clamp count", npulse, 2);
    check("R4 short clamp second", pulse_pos[1], 8);
    setup(1'b0, 1'b0, 16'h0040);
    ticks(1'b0, 4);
    check("R4 short at floor", pulse_pos[0], 4);
    setup(1'b1, 1'b0, 16'h0000);
    ticks(1'b1, 544);
    check("R4 high band clamp", pulse_pos[0], 544);
  endtask

  task automatic t_inhibit();
    setup(1'b0, 1'b1, 16'd300);
    ticks(1'b0, 100);
    check("R5 no early pulse", npulse, 0);
    inhibit = 1'b1;
    ticks(1'b0, 500);
    check("R5 silent while inhibited", npulse, 0);
    inhibit = 1'b0;
    ticks(1'b0, 600);
    check("R5 restart first", pulse_pos[0], 300);
    check("R5 restart second", pulse_pos[1], 600);
    setup(1'b1, 1'b0, 16'd272);
    ticks(1'b1, 301);
    inhibit = 1'b1;
    ticks(1'b1, 10);
    check("R5 high band silent", npulse, 0);
    inhibit = 1'b0;
    ticks(1'b1, 544);
    check("R5 high band restart", pulse_pos[0], 544);
    check("R5 high band count", npulse, 1);
  endtask

  task automatic t_change();
    setup(1'b0, 1'b1, 16'd300);
    ticks(1'b0, 100);
    div_word = 16'd280;
    ticks(1'b0, 480);
    check("R6 old period kept", pulse_pos[0], 200);
    check("R6 new period used", pulse_pos[1], 480);
    setup(1'b0, 1'b1, 16'd300);
    ticks(1'b0, 50);
    lb_wide = 1'b0;
    div_word = 16'h0050;
    ticks(1'b0, 260);
    check("R6 mode change count", npulse, 3);
    check("R6 mode old period", pulse_pos[0], 250);
    check("R6 mode new period", pulse_pos[2], 260);
  endtask

  task automatic t_ignore();
    setup(1'b1, 1'b0, 16'd272);
    ticks(1'b0, 1000);
    check("R8 low band ignored", npulse, 0);
    ticks(1'b1, 544);
    check("R8 high band unaffected", pulse_pos[0], 544);
    setup(1'b0, 1'b1, 16'd272);
    ticks(1'b1, 1000);
    check("R8 high band ignored", npulse, 0);
    ticks(1'b0, 272);
    check("R8 low band unaffected", pulse_pos[0], 272);
  endtask

  initial begin
    #(20 * 190000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_high_band();
    t_low_wide();
    t_low_short();
    t_clamp();
    t_inhibit();
    t_change();
    t_ignore();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule